// File: doc/BRIEF.md
# Carrier Frequency Sweep Ramp

This block produces a frequency-offset word that climbs steadily, in steps, while it is enabled. The word is added to the frequency path of a carrier-recovery loop. When the offset is larger than the loop can pull in alone, or when the signal-to-noise ratio is poor, the ramp sweeps the loop across the offset range so that it can lock.

The slope of the ramp comes from two fields of one control byte. A prescaler divides the clock by (N+1), where N is a 4-bit field. On each terminal count of the prescaler, a wide accumulator grows by 2^S LSBs, where S is a 1-bit step select. The accumulator wraps modulo 2^ACC_W and gives a one-cycle pulse when it does.

When the enable bit is 0, the output is zero, and both the accumulator and the prescaler are held at zero. Every sweep therefore starts from the origin. The control byte is written over a plain strobe-and-data port and can always be read back.

Top module: `sweep_ramp`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x01, `ramp_out` is 0 and `ramp_wrap` is 0.
- R2: In the control byte, bit 5 is the enable, bit 4 is the step select and bits 3..0 are the divider N. A write with `cfg_wr` high shows on `cfg_rdata` from the next cycle. `cfg_rdata` returns bits 5..0 as written and reads bits 7..6 as 0.
- R3: While the enable bit is 0, `ramp_out` is exactly 0 and `ramp_wrap` is 0. This holds from the clock edge at which the enable is cleared.
- R4: While enabled, the value advances once every N+1 clock edges. The first advance is on the (N+1)th edge after the edge that wrote the enable.
- R5: Each advance adds 1 when the step select is 0 and 2 when it is 1.
- R6: Clearing the enable resets both the accumulator and the prescaler. When the ramp is enabled again, it restarts from 0 and waits a full N+1 edges before the first advance.
- R7: The value wraps modulo 2^ACC_W. `ramp_wrap` is high for exactly the one cycle in which the wrapped value is first shown.
- R8: If N is lowered while the prescaler count is already at or above the new N, the next edge is a terminal count.
- R9: `ramp_out` is the accumulator value read as a two's-complement number of ACC_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| ramp_out | output | ACC_W | Signed sweep offset word |
| ramp_wrap | output | 1 | One-cycle pulse when the accumulator wraps |

## Verification
The checker watches several rules on every cycle:
- the zero output and the silent wrap flag while the ramp is disabled;
- the readback of each write one cycle later, with the upper bits clear;
- the size of each advance for the current step select;
- the link between a wrap pulse and a falling value.

Some behaviours only the bench scenarios can show. These are the exact number of edges before each advance, the restart from zero after a disable, the early terminal count after the divider is lowered, and the full wrap-around. The bench covers them by running a reduced-width instance against a cycle model and closed-form counts.

// File: rtl/sweep_ramp_pkg.sv
package sweep_ramp_pkg;
   localparam int unsigned CTRL_W      = 8;
   localparam int unsigned DIV_FIELD_W = 4;
   localparam int unsigned EN_POS      = 5;
   localparam int unsigned STEP_POS    = 4;
   localparam int unsigned DIV_LSB     = 0;
   localparam int unsigned USED_W      = 6;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h01;

   typedef struct packed {
      logic                   en;
      logic                   step;
      logic [DIV_FIELD_W-1:0] div;
   } ramp_ctrl_t;

   function automatic ramp_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] b);
      ramp_ctrl_t c;
      c.en   = b[EN_POS];
      c.step = b[STEP_POS];
      c.div  = b[DIV_LSB +: DIV_FIELD_W];
      return c;
   endfunction
endpackage

// File: rtl/sweep_ramp_cfg.sv
module sweep_ramp_cfg
   import sweep_ramp_pkg::*;
#(
   parameter int unsigned REG_W = CTRL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output ramp_ctrl_t       ctrl
);
   localparam int unsigned PAD_W = REG_W - USED_W;

   generate
      if (REG_W < USED_W) begin : g_bad_width
         $error("sweep_ramp_cfg: REG_W too small for the control fields");
      end
   endgenerate

   logic [USED_W-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= CTRL_RESET[USED_W-1:0];
      end else if (wr) begin
         used_q <= wdata[USED_W-1:0];
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, used_q};
      end else begin : g_nopad
         assign rdata = used_q;
      end
   endgenerate

   assign ctrl = unpack_ctrl(rdata);
endmodule

// File: rtl/sweep_ramp_presc.sv
module sweep_ramp_presc #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("sweep_ramp_presc: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   // A count at or beyond the limit is terminal, so lowering the limit acts at once.
   assign tick = run && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sweep_ramp_acc.sv
module sweep_ramp_acc #(
   parameter int unsigned ACC_W  = 26,
   parameter int unsigned STEP_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [STEP_W-1:0] step,
   output logic [ACC_W-1:0]  acc,
   output logic              wrap
);
   localparam int unsigned MAX_SHIFT = (1 << STEP_W) - 1;

   generate
      if (MAX_SHIFT >= ACC_W) begin : g_bad_acc
         $error("sweep_ramp_acc: largest step does not fit the accumulator");
      end
   endgenerate

   logic [ACC_W-1:0] inc;
   logic [ACC_W:0]   sum;

   generate
      if (STEP_W == 1) begin : g_step_mux
         assign inc = step[0] ? ACC_W'(2) : ACC_W'(1);
      end else begin : g_step_shift
         assign inc = ACC_W'(1) << step;
      end
   endgenerate

   assign sum = {1'b0, acc} + {1'b0, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         wrap <= 1'b0;
      end else if (!run) begin
         acc  <= '0;
         wrap <= 1'b0;
      end else if (tick) begin
         acc  <= sum[ACC_W-1:0];
         wrap <= sum[ACC_W];
      end else begin
         wrap <= 1'b0;
      end
   end
endmodule

// File: rtl/sweep_ramp.sv
module sweep_ramp
   import sweep_ramp_pkg::*;
#(
   parameter int unsigned ACC_W = 26,
   parameter int unsigned DIV_W = DIV_FIELD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [CTRL_W-1:0]        cfg_wdata,
   output logic [CTRL_W-1:0]        cfg_rdata,
   output logic signed [ACC_W-1:0]  ramp_out,
   output logic                     ramp_wrap
);
   generate
      if (DIV_W != DIV_FIELD_W) begin : g_bad_div
         $error("sweep_ramp: DIV_W must match the control byte divider field");
      end
      if (ACC_W < 4) begin : g_bad_acc
         $error("sweep_ramp: ACC_W must be at least 4");
      end
   endgenerate

   ramp_ctrl_t       ctrl;
   logic             tick;
   logic [ACC_W-1:0] acc;
   logic             wrap_q;

   sweep_ramp_cfg #(.REG_W(CTRL_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .ctrl  (ctrl)
   );

   sweep_ramp_presc #(.DIV_W(DIV_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl.en),
      .div   (ctrl.div),
      .tick  (tick)
   );

   sweep_ramp_acc #(.ACC_W(ACC_W), .STEP_W(1)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl.en),
      .tick  (tick),
      .step  (ctrl.step),
      .acc   (acc),
      .wrap  (wrap_q)
   );

   // The gate makes the output zero in the very cycle the enable drops.
   assign ramp_out  = ctrl.en ? signed'(acc) : '0;
   assign ramp_wrap = ctrl.en & wrap_q;
endmodule

// File: rtl/sweep_ramp_chk.sv
module sweep_ramp_chk #(
   parameter int unsigned ACC_W = 26,
   parameter int unsigned DIV_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_wr,
   input logic [7:0]              cfg_wdata,
   input logic [7:0]              cfg_rdata,
   input logic signed [ACC_W-1:0] ramp_out,
   input logic                    ramp_wrap
);
   logic             en_w;
   logic [ACC_W-1:0] inc_w;
   logic [ACC_W-1:0] out_u;

   assign en_w  = cfg_rdata[5];
   assign inc_w = cfg_rdata[4] ? ACC_W'(2) : ACC_W'(1);
   assign out_u = $unsigned(ramp_out);

   AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en_w |-> (ramp_out == '0 && !ramp_wrap)); // R3

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[7:6] == 2'b00); // R2

   AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rdata[5:0] == $past(cfg_wdata[5:0])); // R2

   AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w && $past(en_w) && $stable(cfg_rdata) && out_u != $past(out_u))
      |-> (ACC_W'(out_u - $past(out_u)) == $past(inc_w))); // R5

   AST_WRAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_wrap |-> (en_w && out_u < $past(out_u))); // R7

   AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_wrap |=> !ramp_wrap); // R7
endmodule

bind sweep_ramp sweep_ramp_chk #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .ramp_out  (ramp_out),
   .ramp_wrap (ramp_wrap)
);

// File: tb/sweep_ramp_tb.sv
module sweep_ramp_tb;
   localparam int unsigned AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_wdata = 8'h00;
   logic [7:0]    cfg_rdata;
   logic signed [AW-1:0] ramp_out;
   logic          ramp_wrap;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sweep_ramp #(.ACC_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .ramp_out(ramp_out), .ramp_wrap(ramp_wrap)
   );

   // Cycle model built from the requirements.
   logic [5:0]    m_ctrl;
   logic [3:0]    m_cnt;
   logic [AW-1:0] m_acc;
   logic          m_wrap;

   function automatic logic [AW:0] next_sum(input logic [AW-1:0] a, input logic s);
      return {1'b0, a} + (s ? (AW+1)'(2) : (AW+1)'(1));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl <= 6'h01; m_cnt <= '0; m_acc <= '0; m_wrap <= 1'b0;
      end else begin
         if (cfg_wr) m_ctrl <= cfg_wdata[5:0];
         if (!m_ctrl[5]) begin
            m_cnt <= '0; m_acc <= '0; m_wrap <= 1'b0;
         end else if (m_cnt >= m_ctrl[3:0]) begin
            logic [AW:0] s;
            s = next_sum(m_acc, m_ctrl[4]);
            m_cnt <= '0; m_acc <= s[AW-1:0]; m_wrap <= s[AW];
         end else begin
            m_cnt <= m_cnt + 1'b1; m_wrap <= 1'b0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic step_model(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R9 model out", 32'($unsigned(ramp_out)), 32'(m_ctrl[5] ? m_acc : '0));
         chk("R7 model wrap", 32'(ramp_wrap), 32'(m_ctrl[5] & m_wrap));
         chk("R2 model rdata", 32'(cfg_rdata), {26'd0, m_ctrl});
      end
   endtask

   task automatic wait_edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int guard = 0;
      while (!done && guard < 150000) begin @(posedge clk); guard++; end
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=finish", guard);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      wait_edges(3);
      chk("R1 rdata", 32'(cfg_rdata), 32'h01);
      chk("R1 out", 32'($unsigned(ramp_out)), 0);
      chk("R1 wrap", 32'(ramp_wrap), 0);
      rst_n = 1'b1;
      wait_edges(2);

      // R2: readback masks bits 7..6
      wr_ctrl(8'hC7);
      chk("R2 readback", 32'(cfg_rdata), 32'h07);
      chk("R3 off out", 32'($unsigned(ramp_out)), 0);

      // R4 / R5: div=3 step=0 -> value k after 4k edges
      wr_ctrl(8'h23);
      chk("R4 start", 32'($unsigned(ramp_out)), 0);
      wait_edges(3);
      chk("R4 before tick", 32'($unsigned(ramp_out)), 0);
      wait_edges(1);
      chk("R4 first tick", 32'($unsigned(ramp_out)), 1);
      wait_edges(8);
      chk("R4 third tick", 32'($unsigned(ramp_out)), 3);

      // R3: disable zeroes output at once
      wr_ctrl(8'h03);
      chk("R3 zero on disable", 32'($unsigned(ramp_out)), 0);
      wait_edges(2);
      chk("R3 zero held", 32'($unsigned(ramp_out)), 0);

      // R6 / R5: restart div=1 step=1
      wr_ctrl(8'h31);
      wait_edges(1);
      chk("R6 full period", 32'($unsigned(ramp_out)), 0);
      wait_edges(1);
      chk("R5 step two", 32'($unsigned(ramp_out)), 2);
      wait_edges(4);
      chk("R5 step two again", 32'($unsigned(ramp_out)), 6);

      // R8: lower divider while count is high
      wr_ctrl(8'h00);
      wr_ctrl(8'h27);
      wait_edges(4);
      chk("R8 pre", 32'($unsigned(ramp_out)), 0);
      wr_ctrl(8'h22);
      chk("R8 pre2", 32'($unsigned(ramp_out)), 0);
      wait_edges(0);
      @(negedge clk);
      chk("R8 early tick", 32'($unsigned(ramp_out)), 1);

      // R7 / R9: full wrap with div=0 step=1
      wr_ctrl(8'h00);
      wr_ctrl(8'h30);
      wait_edges(2047);
      chk("R9 top negative", 32'($unsigned(ramp_out)), 32'(4094));
      chk("R9 sign", 32'(ramp_out < 0), 1);
      chk("R7 no early wrap", 32'(ramp_wrap), 0);
      wait_edges(1);
      chk("R7 wrapped value", 32'($unsigned(ramp_out)), 0);
      chk("R7 wrap pulse", 32'(ramp_wrap), 1);
      wait_edges(1);
      chk("R7 wrap one cycle", 32'(ramp_wrap), 0);

      // Random control writes against the cycle model (R2..R8)
      for (int it = 0; it < 60; it++) begin
         logic [7:0] v;
         v = 8'($urandom);
         if ($urandom % 4 != 0) v[5] = 1'b1;
         @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
         step_model(1);
         cfg_wr = 1'b0;
         step_model(5 + int'($urandom % 50));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule